// File: doc/BRIEF.md
# Receive Clock Gating Controller

This block sits between a 100 Mb/s PHY receive path and the MAC. It takes the free-running receive clock and produces a gated copy that stops (held low) while no frame is arriving. Receive data-valid and data are passed through a one-stage register so the gate can open on the edge that launches the first valid nibble. The gate closes again after a fixed quiet tail once data-valid has dropped.

Gating is active only when the enable input is set, the link runs in 100 Mb/s mode, and neither loopback nor PCS bypass is selected. In every other case, and while reset is held, the output clock runs on every cycle. The gate enable passes through a latch that is transparent only while the clock is low, so the output clock never carries a shortened pulse.

Top module: `rxcg_top`

## Requirements
- R1: `rx_dv_out` and `rx_data_out` equal `rx_dv_in` and `rx_data_in` as sampled at the previous rising edge of `clk_rx`.
- R2: With `gate_en` low, `rx_clk_gated` produces a high pulse in every `clk_rx` cycle.
- R3: With gating active and no frame for more than the tail length, `rx_clk_gated` stays low.
- R4: From idle, the first gated pulse occurs at the same edge at which `rx_dv_out` goes high, and there is no pulse in the cycle before it. The MAC therefore sees exactly one gated edge with data-valid low before the first edge with it high.
- R5: After `rx_dv_out` falls, gated pulses continue in that cycle and in the next TAIL_CYCLES cycles (default 64), then stop.
- R6: If `rx_dv_in` rises again during the tail, the countdown is cancelled and the gated clock keeps running with no missing pulse.
- R7: With `mode_100` low (any other speed), the clock runs freely.
- R8: With `loopback` high, the clock runs freely.
- R9: With `pcs_bypass` high, the clock runs freely.
- R10: `rx_clk_gated` is low whenever `clk_rx` is low, and the gate enable changes only while `clk_rx` is low, so no runt pulses occur.
- R11: While `rst_n` is low, the clock runs and `rx_dv_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Free-running receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_en | input | 1 | Gating enable (set by a control register that resets to 0) |
| mode_100 | input | 1 | High when the link runs at 100 Mb/s |
| loopback | input | 1 | High when loopback is selected |
| pcs_bypass | input | 1 | High when PCS bypass is selected |
| rx_dv_in | input | 1 | Data-valid from the PHY core |
| rx_data_in | input | DATA_W | Receive data from the PHY core |
| rx_clk_gated | output | 1 | Gated receive clock toward the MAC |
| rx_dv_out | output | 1 | Data-valid, delayed one cycle |
| rx_data_out | output | DATA_W | Receive data, delayed one cycle |

## Verification
The assertions assume that all inputs change only while `clk_rx` is low, and that `rx_dv_in` is low during reset and on the edge that releases it. The bench meets both conditions by driving every input at the falling edge and holding data-valid low until after reset is released. The mode inputs are only changed while the line is idle and the tail has run out, so a speed or loopback change never coincides with a falling data-valid.

// File: rtl/rxcg_pkg.sv
package rxcg_pkg;

  // Gating takes effect only in the one speed mode with no override present.
  function automatic logic gate_active(input logic en, input logic m100,
                                       input logic lpbk, input logic bypass);
    return en & m100 & ~lpbk & ~bypass;
  endfunction

  // Next value of the tail counter.
  function automatic logic [15:0] tail_next(input logic active, input logic dv_in,
                                            input logic dv_q, input logic [15:0] cnt,
                                            input logic [15:0] tail_len);
    if (!active || dv_in) return 16'd0;
    if (dv_q)             return tail_len;
    if (cnt != 16'd0)     return cnt - 16'd1;
    return 16'd0;
  endfunction

endpackage

// File: rtl/rxcg_delay.sv
module rxcg_delay #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dv_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              dv_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      data_q <= '0;
    end else begin
      dv_q   <= dv_in;
      data_q <= data_in;
    end
  end

  // R1: a one-cycle delay of data-valid
  a_r1_dv_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dv_in |=> dv_q);
  a_r1_dv_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !dv_in |=> !dv_q);

endmodule

// File: rtl/rxcg_tail.sv
module rxcg_tail
  import rxcg_pkg::*;
#(
  parameter int TAIL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic dv_in,
  input  logic dv_q,
  output logic tail_busy
);

  localparam int CW = $clog2(TAIL_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [15:0]   cnt_nxt;

  assign cnt_nxt   = tail_next(active, dv_in, dv_q, 16'(cnt), 16'(TAIL_CYCLES));
  assign tail_busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt[CW-1:0];
  end

  // R5: a falling data-valid always opens the tail
  a_r5_fall_starts_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dv_in && dv_q) |=> tail_busy);
  // R5: the tail shrinks by one per idle cycle
  a_r5_tail_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dv_in && !dv_q && tail_busy) |=> (cnt == $past(cnt) - 1'b1));
  // R6: a new frame cancels the countdown
  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_in && tail_busy) |=> !tail_busy);

endmodule

// File: rtl/rxcg_gate.sv
module rxcg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_gated
);

  logic en_l;
  logic en_at_rise;

  // Transparent only while the clock is low.
  always_latch begin
    if (!clk) en_l = run_req;
  end

  assign clk_gated = clk & en_l;

  always_ff @(posedge clk) en_at_rise <= en_l;

  // R10: enable is frozen through the high phase
  a_r10_enable_stable_high: assert property (@(negedge clk) disable iff (!rst_n)
    en_l == en_at_rise);

  // R10: the output is never high with the source clock low
  always_comb begin
    if (rst_n && !clk) a_r10_no_high_when_low: assert (clk_gated == 1'b0);
  end

endmodule

// File: rtl/rxcg_top.sv
module rxcg_top
  import rxcg_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int TAIL_CYCLES = 64
) (
  input  logic              clk_rx,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              mode_100,
  input  logic              loopback,
  input  logic              pcs_bypass,
  input  logic              rx_dv_in,
  input  logic [DATA_W-1:0] rx_data_in,
  output logic              rx_clk_gated,
  output logic              rx_dv_out,
  output logic [DATA_W-1:0] rx_data_out
);

  logic active;
  logic tail_busy;
  logic run_req;

  assign active  = gate_active(gate_en, mode_100, loopback, pcs_bypass);
  assign run_req = !rst_n || !active || rx_dv_in || rx_dv_out || tail_busy;

  rxcg_delay #(.DATA_W(DATA_W)) u_delay (
    .clk(clk_rx), .rst_n(rst_n),
    .dv_in(rx_dv_in), .data_in(rx_data_in),
    .dv_q(rx_dv_out), .data_q(rx_data_out)
  );

  rxcg_tail #(.TAIL_CYCLES(TAIL_CYCLES)) u_tail (
    .clk(clk_rx), .rst_n(rst_n), .active(active),
    .dv_in(rx_dv_in), .dv_q(rx_dv_out), .tail_busy(tail_busy)
  );

  rxcg_gate u_gate (
    .clk(clk_rx), .rst_n(rst_n), .run_req(run_req), .clk_gated(rx_clk_gated)
  );

  // R11: no data-valid out of reset
  a_r11_reset_quiet: assert property (@(posedge clk_rx) disable iff (!rst_n)
    $rose(rst_n) |-> !rx_dv_out);

endmodule

// File: tb/rxcg_top_bench.sv
module rxcg_top_bench;

  localparam int PERIOD = 10;
  localparam int W      = 4;
  localparam int TAIL   = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gate_en = 1'b0, mode_100 = 1'b1, loopback = 1'b0, pcs_bypass = 1'b0;
  logic         dv_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         clk_g, dv_out;
  logic [W-1:0] data_out;

  always #(PERIOD/2) clk = ~clk;

  rxcg_top #(.DATA_W(W), .TAIL_CYCLES(TAIL)) u_rxcg_top (
    .clk_rx(clk), .rst_n(rst_n), .gate_en(gate_en), .mode_100(mode_100),
    .loopback(loopback), .pcs_bypass(pcs_bypass), .rx_dv_in(dv_in),
    .rx_data_in(data_in), .rx_clk_gated(clk_g), .rx_dv_out(dv_out),
    .rx_data_out(data_out)
  );

  typedef struct packed {
    logic         pulse;
    logic         dv;
    logic [W-1:0] data;
    logic [7:0]   req;
  } item_t;

  item_t q[$];
  int    checks = 0, errors = 0;
  int    cur_req = 1;
  bit    done = 0;

  // reference state, from the requirements
  logic mdl_dvq = 1'b0;
  int   mdl_cnt = 0;

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge and predict the next cycle.
  task automatic drive(input logic dv, input logic [W-1:0] d);
    logic act;
    item_t it;
    @(negedge clk);
    dv_in   = dv;
    data_in = d;
    act = gate_en && mode_100 && !loopback && !pcs_bypass;
    it.pulse = !act || dv || mdl_dvq || (mdl_cnt != 0);
    it.dv    = dv;
    it.data  = d;
    it.req   = 8'(cur_req);
    q.push_back(it);
    if (!act || dv)    mdl_cnt = 0;
    else if (mdl_dvq)  mdl_cnt = TAIL;
    else if (mdl_cnt != 0) mdl_cnt = mdl_cnt - 1;
    mdl_dvq = dv;
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, W'($urandom));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, W'($urandom));
  endtask

  // Monitor: pop and compare in the high phase, check low phase too.
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(int'(it.req), "gated clock pulse", clk_g, it.pulse);
        chk(int'(it.req), "data-valid out", dv_out, it.dv);
        if (it.dv) chk(1, "data out", (data_out === it.data), 1'b1);  // R1
      end
      @(negedge clk); #2;
      if (rst_n) chk(10, "clock low in low phase", clk_g, 1'b0);      // R10
    end
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset behaviour
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      if (i > 0) begin
        chk(11, "clock runs in reset", clk_g, 1'b1);
        chk(11, "dv low in reset", dv_out, 1'b0);
      end
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 and R1: gating disabled, frames pass one cycle late
    cur_req = 2; idle(3); frame(5); idle(10);

    // R3: enabled, long idle stays quiet
    @(negedge clk); gate_en = 1'b1;
    cur_req = 3; idle(80);
    // R4: restart edge aligned with data-valid
    cur_req = 4; frame(6);
    // R5: tail of TAIL cycles then stop
    cur_req = 5; idle(75);
    // R4 with single-cycle frame, then R5 again
    cur_req = 4; frame(1);
    cur_req = 5; idle(70);
    // R6: new frame inside the tail
    cur_req = 6; frame(3); idle(30); frame(4); idle(TAIL); frame(2); idle(70);

    // R7: other speed
    @(negedge clk); mode_100 = 1'b0;
    cur_req = 7; idle(5); frame(3); idle(80);
    @(negedge clk); mode_100 = 1'b1;
    cur_req = 3; idle(70);
    // R8: loopback
    @(negedge clk); loopback = 1'b1;
    cur_req = 8; idle(5); frame(3); idle(80);
    @(negedge clk); loopback = 1'b0;
    cur_req = 3; idle(70);
    // R9: PCS bypass
    @(negedge clk); pcs_bypass = 1'b1;
    cur_req = 9; idle(5); frame(3); idle(80);
    @(negedge clk); pcs_bypass = 1'b0;
    cur_req = 3; idle(70);

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule